// File: doc/BRIEF.md
# Programmable-Gain Mixing Demodulator

This block brings a sampled photodetector-style signal down to baseband. Each clock it may take one 14-bit two's-complement sample and multiply it by a digital gain. The gain is a left shift of 0 to 15 places. The shifted word is then multiplied by a 16-bit signed sine from an internal local oscillator, and the upper half of the product goes on to a downstream filter chain. A bypass bit skips the multiply and passes the shifted sample straight through, which is useful when probing the input path.

The local oscillator is a 16-bit phase accumulator. It advances by the same frequency word that drives the modulation source elsewhere in the chip, so the two stay locked. A separate 16-bit phase offset lets software set the demodulation phase. Gain is a plain shift that lets high bits fall off and wrap. Software is expected to lower the shift when the input gets large.

Top module: `mixdemod_top`

## Requirements
- R1: While reset is held, and in the first cycle after it, `out_valid` is 0 and `out_data` is 0.
- R2: `out_valid` in a cycle equals `in_valid` exactly four clock cycles earlier, with no bubbles and no extra pulses.
- R3: The gain stage sign-extends the sample to 16 bits and shifts it left by `gain_shift` places. Only the low 16 bits are kept, so overflow wraps with no saturation. A shift of 0 gives unity gain.
- R4: In mixing mode, `out_data` is bits 31:16 of the signed 32-bit product of the 16-bit gain word and the oscillator sine. It is therefore 0 for a zero sample.
- R5: After reset the phase accumulator holds 0. It adds `freq_word` modulo 2^16 on every clock edge outside reset, whether or not a sample is present. A sample uses address bits 15:6 of (accumulator + `phase_ofs`), taken at the edge where the sample is accepted.
- R6: For table address a (0..1023), the sine equals round(32767·sin(2π(a+0.5)/1024)) to within one LSB. It has odd symmetry about half a turn and even symmetry about each quarter turn.
- R7: When `bypass_en` is 1 for a sample, the matching `out_data` is exactly the 16-bit gain word from R3, with no multiply.
- R8: In any cycle after reset where `out_valid` is 0, `out_data` holds its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock (100 MHz) |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A sample is present this cycle |
| in_sample | input | 14 | Two's-complement input sample |
| gain_shift | input | 4 | Left-shift amount, 0 = unity |
| freq_word | input | 16 | Oscillator phase increment per clock |
| phase_ofs | input | 16 | Phase offset added before the sine lookup |
| bypass_en | input | 1 | 1 = pass the gain word through unmixed |
| out_valid | output | 1 | Result present this cycle |
| out_data | output | 16 | Mixed or bypassed result |

## Verification
With the frequency word at zero and the phase offset set to each quarter turn, a near-full-scale sample shows whether the sine folds correctly in each quadrant and whether the output takes the upper product half with the right sign. In bypass mode, samples at both extremes with large shifts separate a wrapping shifter from a saturating one or a wrongly extended one. Random runs with a non-zero frequency word, random offsets and gaps in `in_valid` tell apart an accumulator that steps every clock from one that steps only on valid samples. They also expose an off-by-one latency and any output that moves while no result is valid.

// File: rtl/mixdemod_pkg.sv
package mixdemod_pkg;

    localparam int SAMPLE_W = 14;
    localparam int SHIFT_W  = 4;
    localparam int WORD_W   = 16;
    localparam int PHASE_W  = 16;
    localparam int ADDR_W   = 10;
    localparam int QIDX_W   = ADDR_W - 2;
    localparam int QDEPTH   = 1 << QIDX_W;
    localparam int PROD_W   = 2 * WORD_W;
    localparam int LATENCY  = 4;

    localparam longint ONE_Q30     = 64'sd1073741824;
    localparam longint PI_HALF_Q30 = 64'sd1686629713;
    localparam longint AMP         = 64'sd32767;

    // stage after input capture
    typedef struct packed {
        logic                    valid;
        logic                    bypass;
        logic [WORD_W-1:0]       word;
        logic [ADDR_W-1:0]       addr;
    } cap_t;

    // stage after sine lookup
    typedef struct packed {
        logic                    valid;
        logic                    bypass;
        logic [WORD_W-1:0]       word;
    } lut_t;

    // stage after the multiply
    typedef struct packed {
        logic                    valid;
        logic                    bypass;
        logic [WORD_W-1:0]       word;
        logic [WORD_W-1:0]       hi;
    } mul_t;

    // Sign-extend and shift, keeping only the low WORD_W bits (wraps).
    function automatic logic [WORD_W-1:0] gain_word(
        input logic [SAMPLE_W-1:0] s,
        input logic [SHIFT_W-1:0]  sh
    );
        logic [WORD_W-1:0] ext;
        ext = {{(WORD_W-SAMPLE_W){s[SAMPLE_W-1]}}, s};
        return ext << sh;
    endfunction

    // Quarter-wave table entry k: AMP*sin(pi/2*(k+0.5)/QDEPTH), integer Taylor series.
    function automatic logic [WORD_W-1:0] sine_q(input int k);
        longint x;
        longint x2;
        longint t;
        longint r;
        x  = (PI_HALF_Q30 * longint'(2 * k + 1)) / longint'(2 * QDEPTH);
        x2 = (x * x) >>> 30;
        t  = ONE_Q30;
        t  = ONE_Q30 - ((x2 * t) >>> 30) / 110;
        t  = ONE_Q30 - ((x2 * t) >>> 30) / 72;
        t  = ONE_Q30 - ((x2 * t) >>> 30) / 42;
        t  = ONE_Q30 - ((x2 * t) >>> 30) / 20;
        t  = ONE_Q30 - ((x2 * t) >>> 30) / 6;
        r  = (x * t) >>> 30;
        r  = (r * AMP + (ONE_Q30 >>> 1)) >>> 30;
        return WORD_W'(r);
    endfunction

endpackage

// File: rtl/mixdemod_nco.sv
module mixdemod_nco
    import mixdemod_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [PHASE_W-1:0] freq_word,
    input  logic [PHASE_W-1:0] phase_ofs,
    output logic [ADDR_W-1:0]  lut_addr
);

    logic [PHASE_W-1:0] acc_q;
    logic [PHASE_W-1:0] phase_sum;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
        end else begin
            acc_q <= acc_q + freq_word;
        end
    end

    always_comb begin
        phase_sum = acc_q + phase_ofs;
        lut_addr  = ADDR_W'(phase_sum >> (PHASE_W - ADDR_W));
    end

endmodule

// File: rtl/mixdemod_sine_rom.sv
module mixdemod_sine_rom
    import mixdemod_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    output logic [WORD_W-1:0] sine
);

    logic [WORD_W-1:0] quarter [QDEPTH];

    for (genvar i = 0; i < QDEPTH; i++) begin : g_tab
        localparam logic [WORD_W-1:0] ENTRY = sine_q(i);
        assign quarter[i] = ENTRY;
    end

    logic              neg_half;
    logic              mirror;
    logic [QIDX_W-1:0] idx;
    logic [WORD_W-1:0] mag;
    logic [WORD_W-1:0] folded;

    always_comb begin
        neg_half = addr[ADDR_W-1];
        mirror   = addr[ADDR_W-2];
        idx      = mirror ? ~addr[QIDX_W-1:0] : addr[QIDX_W-1:0];
        mag      = quarter[idx];
        folded   = neg_half ? (~mag + 1'b1) : mag;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sine <= '0;
        end else if (rd_en) begin
            sine <= folded;
        end
    end

endmodule

// File: rtl/mixdemod_mixer.sv
module mixdemod_mixer
    import mixdemod_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  lut_t              lut_in,
    input  logic [WORD_W-1:0] sine,
    output logic              res_valid,
    output logic [WORD_W-1:0] res_data
);

    logic signed [PROD_W-1:0] prod;
    logic signed [PROD_W-1:0] prod_shr;
    mul_t                     mul_q;

    always_comb begin
        prod     = $signed(lut_in.word) * $signed(sine);
        prod_shr = prod >>> WORD_W;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mul_q <= '0;
        end else begin
            mul_q.valid <= lut_in.valid;
            if (lut_in.valid) begin
                mul_q.bypass <= lut_in.bypass;
                mul_q.word   <= lut_in.word;
                mul_q.hi     <= WORD_W'(prod_shr);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid <= 1'b0;
            res_data  <= '0;
        end else begin
            res_valid <= mul_q.valid;
            if (mul_q.valid) begin
                res_data <= mul_q.bypass ? mul_q.word : mul_q.hi;
            end
        end
    end

endmodule

// File: rtl/mixdemod_top.sv
module mixdemod_top
    import mixdemod_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic [SAMPLE_W-1:0] in_sample,
    input  logic [SHIFT_W-1:0]  gain_shift,
    input  logic [PHASE_W-1:0]  freq_word,
    input  logic [PHASE_W-1:0]  phase_ofs,
    input  logic                bypass_en,
    output logic                out_valid,
    output logic [WORD_W-1:0]   out_data
);

    logic [ADDR_W-1:0] lo_addr;
    cap_t              cap_q;
    lut_t              lut_q;
    logic [WORD_W-1:0] sine_val;

    mixdemod_nco u_nco (
        .clk       (clk),
        .rst       (rst),
        .freq_word (freq_word),
        .phase_ofs (phase_ofs),
        .lut_addr  (lo_addr)
    );

    // stage 1: gain shift and phase capture
    always_ff @(posedge clk) begin
        if (rst) begin
            cap_q <= '0;
        end else begin
            cap_q.valid <= in_valid;
            if (in_valid) begin
                cap_q.bypass <= bypass_en;
                cap_q.word   <= gain_word(in_sample, gain_shift);
                cap_q.addr   <= lo_addr;
            end
        end
    end

    // stage 2: sine lookup alongside the sample
    mixdemod_sine_rom u_rom (
        .clk   (clk),
        .rst   (rst),
        .rd_en (cap_q.valid),
        .addr  (cap_q.addr),
        .sine  (sine_val)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            lut_q <= '0;
        end else begin
            lut_q.valid <= cap_q.valid;
            if (cap_q.valid) begin
                lut_q.bypass <= cap_q.bypass;
                lut_q.word   <= cap_q.word;
            end
        end
    end

    // stages 3 and 4: multiply and output select
    mixdemod_mixer u_mix (
        .clk       (clk),
        .rst       (rst),
        .lut_in    (lut_q),
        .sine      (sine_val),
        .res_valid (out_valid),
        .res_data  (out_data)
    );

endmodule

// File: rtl/mixdemod_chk.sv
module mixdemod_chk
    import mixdemod_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                in_valid,
    input logic [SAMPLE_W-1:0] in_sample,
    input logic [SHIFT_W-1:0]  gain_shift,
    input logic                bypass_en,
    input logic                out_valid,
    input logic [WORD_W-1:0]   out_data
);

    logic [2:0] since_rst;

    always_ff @(posedge clk) begin
        if (rst) begin
            since_rst <= '0;
        end else if (since_rst != 3'd7) begin
            since_rst <= since_rst + 3'd1;
        end
    end

    // R1: reset clears the output side
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (!out_valid && out_data == '0));

    // R2: fixed four-cycle valid latency
    p_latency_r2: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 3'd5) |-> (out_valid == $past(in_valid, 4)));

    // R4: zero sample in mixing mode gives zero
    p_zero_mix_r4: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 3'd5 && $past(in_valid, 4) && !$past(bypass_en, 4)
         && $past(in_sample, 4) == '0) |-> (out_data == '0));

    // R7: bypass with unity gain returns the sign-extended sample
    p_bypass_unity_r7: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 3'd5 && $past(in_valid, 4) && $past(bypass_en, 4)
         && $past(gain_shift, 4) == '0)
        |-> (out_data == WORD_W'($signed($past(in_sample, 4)))));

    // R8: output data holds while no result is valid
    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 3'd2 && !out_valid) |-> $stable(out_data));

endmodule

bind mixdemod_top mixdemod_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_sample  (in_sample),
    .gain_shift (gain_shift),
    .bypass_en  (bypass_en),
    .out_valid  (out_valid),
    .out_data   (out_data)
);

// File: tb/mixdemod_top_bench.sv
module mixdemod_top_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [13:0] in_sample = '0;
    logic [3:0]  gain_shift = '0;
    logic [15:0] freq_word = '0;
    logic [15:0] phase_ofs = '0;
    logic        bypass_en = 1'b0;
    logic        out_valid;
    logic [15:0] out_data;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    mixdemod_top u_mixdemod_top (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_sample  (in_sample),
        .gain_shift (gain_shift),
        .freq_word  (freq_word),
        .phase_ofs  (phase_ofs),
        .bypass_en  (bypass_en),
        .out_valid  (out_valid),
        .out_data   (out_data)
    );

    // R3: sign-extend to 16 bits, shift, keep the low 16 bits
    function automatic int exp_word(input logic [13:0] s, input logic [3:0] sh);
        logic [15:0] w;
        w = {{2{s[13]}}, s};
        w = w << sh;
        return int'($signed(w));
    endfunction

    // R6: rounded sine at address a
    function automatic int exp_sine(input int a);
        real v;
        v = 32767.0 * $sin(2.0 * 3.14159265358979 * (real'(a) + 0.5) / 1024.0);
        if (v >= 0.0) return $rtoi(v + 0.5);
        return -$rtoi(-v + 0.5);
    endfunction

    // R4: upper half of the signed product
    function automatic int exp_mix(input int w, input int s);
        longint p;
        p = longint'(w) * longint'(s);
        return int'(p >>> 16);
    endfunction

    // reference model of the phase and the valid pipe (R2, R5)
    logic [15:0] acc_m = '0;
    logic [3:0]  vpipe = '0;
    int          exp_q[$];
    bit          byp_q[$];

    always @(posedge clk) begin
        if (rst) begin
            acc_m = '0;
            vpipe = '0;
        end else begin
            if (in_valid) begin
                logic [15:0] ph;
                int          w;
                ph = acc_m + phase_ofs;
                w  = exp_word(in_sample, gain_shift);
                if (bypass_en) exp_q.push_back(w);
                else           exp_q.push_back(exp_mix(w, exp_sine(int'(ph[15:6]))));
                byp_q.push_back(bypass_en);
            end
            acc_m = acc_m + freq_word;
            vpipe = {vpipe[2:0], in_valid};
        end
    end

    logic [15:0] last_out = '0;

    always @(negedge clk) begin
        if (!rst && !done) begin
            tests++;
            if (out_valid !== vpipe[3]) begin
                fails++;
                $display("FAIL R2 valid latency: got %0b exp %0b", out_valid, vpipe[3]);
            end
            if (out_valid && exp_q.size() > 0) begin
                int  e;
                int  g;
                bit  b;
                e = exp_q.pop_front();
                b = byp_q.pop_front();
                g = int'($signed(out_data));
                tests++;
                if (b) begin
                    if (g != e) begin
                        fails++;
                        $display("FAIL R7/R3 bypass word: got %0d exp %0d", g, e);
                    end
                end else if (g - e > 1 || e - g > 1) begin
                    fails++;
                    $display("FAIL R4/R5/R6 mix result: got %0d exp %0d", g, e);
                end
            end else if (!out_valid) begin
                tests++;
                if (out_data !== last_out) begin
                    fails++;
                    $display("FAIL R8 hold: got %0h exp %0h", out_data, last_out);
                end
            end
            last_out = out_data;
        end
    end

    task automatic drive(input bit v, input logic [13:0] s, input logic [3:0] sh,
                         input bit byp);
        @(negedge clk);
        in_valid   = v;
        in_sample  = s;
        gain_shift = sh;
        bypass_en  = byp;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) drive(1'b0, '0, '0, 1'b0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin : stim
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        @(negedge clk);
        tests++;
        if (out_valid !== 1'b0 || out_data !== 16'h0) begin
            fails++;
            $display("FAIL R1 reset state: got %0b/%0h exp 0/0", out_valid, out_data);
        end
        rst = 1'b0;
        @(negedge clk);
        tests++;
        if (out_valid !== 1'b0 || out_data !== 16'h0) begin
            fails++;
            $display("FAIL R1 after reset: got %0b/%0h exp 0/0", out_valid, out_data);
        end

        // R7 and R3: bypass extremes, unity and wrapping shifts
        drive(1'b1, 14'h1FFF, 4'd0, 1'b1);
        drive(1'b1, 14'h2000, 4'd0, 1'b1);
        drive(1'b1, 14'h1FFF, 4'd3, 1'b1);
        drive(1'b1, 14'h2000, 4'd2, 1'b1);
        drive(1'b1, 14'h0001, 4'd15, 1'b1);
        drive(1'b1, 14'h3FFF, 4'd15, 1'b1);
        idle(6);

        // R5 and R6: fixed phase, one quadrant at a time
        freq_word = 16'h0000;
        for (int q = 0; q < 4; q++) begin
            @(negedge clk);
            phase_ofs = 16'(q) << 14;
            drive(1'b1, 14'h1FFF, 4'd2, 1'b0);
            drive(1'b1, 14'h2000, 4'd2, 1'b0);
            drive(1'b1, 14'h0000, 4'd5, 1'b0);
            idle(2);
        end
        idle(6);

        // R4: mixing with a running oscillator and gaps in valid
        freq_word = 16'h0800;
        phase_ofs = 16'h1234;
        for (int i = 0; i < 64; i++) drive(1'(i % 3 != 0), 14'h0FFF, 4'd1, 1'b0);
        idle(6);

        // random mix of everything
        for (int i = 0; i < 2000; i++) begin
            if (i % 200 == 0) begin
                @(negedge clk);
                freq_word = 16'($urandom);
                phase_ofs = 16'($urandom);
            end
            drive(1'($urandom % 4 != 0), 14'($urandom), 4'($urandom),
                  1'($urandom % 5 == 0));
        end
        idle(8);

        done = 1'b1;
        tests++;
        if (exp_q.size() != 0) begin
            fails++;
            $display("FAIL R2 results missing: got %0d pending exp 0", exp_q.size());
        end
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule